// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers a parameterised number of external interrupt pins. Each pin has its own channel. A channel holds an 8-bit control register and the logic that turns the pin into a request. Every pin is asynchronous, so it is first retimed through a flop chain. After that, the channel either looks for a transition (edge sense) or follows the pin level (level sense). A per-channel polarity bit picks which transition, or which level, counts as active.

A small register port lets software write one channel's control byte in a cycle and read any channel's byte back combinationally. Each channel also has a one-cycle acknowledge input that drops a pending edge-mode request.

Per channel, the block outputs the effective request and the 3-bit priority level. An arbiter then names the winning channel. The winner is the requesting channel with the highest nonzero level; on a tie, the lowest index wins. Level 0 keeps a channel out of arbitration.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00, every channel request is 0 and `win_valid` is 0.
- R2: The control byte layout is: bits 2..0 = priority level, bit 3 = pending flag, bit 4 = polarity, bit 5 = sense mode (1 = level). A write stores bits 5..0. Bits 7..6 ignore writes and always read 0.
- R3: In edge mode with polarity 0, a falling pin edge sets the pending flag. The flag is readable at the third rising clock edge after the pin changes. A rising edge leaves the flag clear.
- R4: In edge mode with polarity 1, a rising pin edge sets the pending flag, and a falling edge leaves it clear.
- R5: In level mode the channel request follows the retimed pin: high is active with polarity 0 and low is active with polarity 1. The stored pending flag has no effect on the request. The request appears two clock edges after the pin changes.
- R6: In edge mode, software sets or clears the pending flag by writing bit 3. If a detected edge and a write land in the same cycle, the flag ends up set.
- R7: A pulse on `ack[i]` clears channel i's pending flag in edge mode. In level mode the acknowledge does not change the request.
- R8: A channel at level 0 still shows its request on `chan_req` but never wins arbitration. `win_valid` is 0 when no requesting channel has a nonzero level.
- R9: The arbiter reports the requesting channel with the highest nonzero level. Equal levels go to the lowest index. `win_lvl` equals the winner's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NCH | Asynchronous external interrupt pins |
| wr_en | input | 1 | Control byte write strobe |
| wr_ch | input | IDX_W | Channel addressed by the write |
| wr_data | input | 8 | Control byte to write |
| rd_ch | input | IDX_W | Channel whose control byte is read |
| rd_data | output | 8 | Control byte of channel `rd_ch` |
| ack | input | NCH | Per-channel acknowledge pulse |
| chan_req | output | NCH | Effective request per channel |
| chan_lvl | output | 3*NCH | Priority level per channel, channel i at bits 3i+2..3i |
| win_valid | output | 1 | Some unmasked channel is requesting |
| win_idx | output | IDX_W | Index of the winning channel |
| win_lvl | output | 3 | Level of the winning channel |

## Verification
The bench builds the block with NCH = 4 and SYNC_STAGES = 2. Four channels are enough to run edge-falling, edge-rising, level and mixed channels side by side, and to set up a tie between two channels at the top level alongside a masked requester. With two retiming stages, the bench can pin the three-edge flag latency and the two-edge level latency to exact cycles. It can also line a software clear up with the hardware edge cycle to test the set-wins rule.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int LVL_W = 3;

  // Control byte fields, bit 5 down to bit 0.
  typedef struct packed {
    logic             lvl_mode;
    logic             pol_hi;
    logic             flag;
    logic [LVL_W-1:0] lvl;
  } ctl_t;

  function automatic ctl_t ctl_from_byte(input logic [5:0] b);
    return ctl_t'(b);
  endfunction

  function automatic logic [7:0] ctl_to_byte(input ctl_t c);
    return {2'b00, c};
  endfunction

  // Transition of interest: rising when rise=1, falling when rise=0.
  function automatic logic edge_seen(input logic prev, input logic cur, input logic rise);
    return rise ? (~prev & cur) : (prev & ~cur);
  endfunction

  // Active level: low when low_act=1, high otherwise.
  function automatic logic level_active(input logic cur, input logic low_act);
    return low_act ? ~cur : cur;
  endfunction

  // True when a candidate level beats the current best (strict, so earlier index keeps ties).
  function automatic logic lvl_beats(input logic [LVL_W-1:0] cand, input logic [LVL_W-1:0] best);
    return cand > best;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eirq_channel.sv
module eirq_channel
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic       wr_hit,
  input  logic [5:0] wr_bits,
  input  logic       ack,
  output ctl_t       ctl_q,
  output logic       req,
  output logic       edge_hit
);
  logic prev_q;
  ctl_t ctl_nxt;

  assign edge_hit = ~ctl_q.lvl_mode & edge_seen(prev_q, pin_s, ctl_q.pol_hi);

  always_comb begin
    ctl_nxt = ctl_q;
    if (ack && !ctl_q.lvl_mode) ctl_nxt.flag = 1'b0;
    if (wr_hit)                 ctl_nxt = ctl_from_byte(wr_bits);
    if (edge_hit)               ctl_nxt.flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_nxt;
      prev_q <= pin_s;
    end
  end

  assign req = ctl_q.lvl_mode ? level_active(pin_s, ctl_q.pol_hi) : ctl_q.flag;
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter
  import eirq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IDX_W = 2
) (
  input  logic [NCH-1:0]       req,
  input  logic [NCH*LVL_W-1:0] lvl,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output logic [LVL_W-1:0]     win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && lvl_beats(lvl[i*LVL_W +: LVL_W], win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter  int NCH         = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       pin_in,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_ch,
  input  logic [7:0]           wr_data,
  input  logic [IDX_W-1:0]     rd_ch,
  output logic [7:0]           rd_data,
  input  logic [NCH-1:0]       ack,
  output logic [NCH-1:0]       chan_req,
  output logic [NCH*LVL_W-1:0] chan_lvl,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output logic [LVL_W-1:0]     win_lvl
);
  ctl_t           ctl_q [NCH];
  logic [NCH-1:0] pin_sync;
  logic [NCH-1:0] edge_hit;
  logic [NCH-1:0] chan_flag;
  logic [NCH-1:0] chan_mode;
  logic           unused_hi;

  assign unused_hi = ^wr_data[7:6];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in[i]), .q(pin_sync[i])
    );

    eirq_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_sync[i]),
      .wr_hit  (wr_en && (wr_ch == IDX_W'(i))),
      .wr_bits (wr_data[5:0]),
      .ack     (ack[i]),
      .ctl_q   (ctl_q[i]),
      .req     (chan_req[i]),
      .edge_hit(edge_hit[i])
    );

    assign chan_lvl[i*LVL_W +: LVL_W] = ctl_q[i].lvl;
    assign chan_flag[i]               = ctl_q[i].flag;
    assign chan_mode[i]               = ctl_q[i].lvl_mode;
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_ch) < NCH) rd_data = ctl_to_byte(ctl_q[rd_ch]);
  end

  eirq_arbiter #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
    .req      (chan_req),
    .lvl      (chan_lvl),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter  int NCH   = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rd_data,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_ch,
  input logic [NCH-1:0]   ack,
  input logic [NCH-1:0]   chan_req,
  input logic [NCH*3-1:0] chan_lvl,
  input logic             win_valid,
  input logic [IDX_W-1:0] win_idx,
  input logic [2:0]       win_lvl,
  input logic [NCH-1:0]   edge_hit,
  input logic [NCH-1:0]   chan_flag,
  input logic [NCH-1:0]   chan_mode
);
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_lvl != 3'd0);

  p_winner_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (chan_req[win_idx] && chan_lvl[win_idx*3 +: 3] == win_lvl));

  for (genvar j = 0; j < NCH; j++) begin : g_chk
    // R3 and R4: a detected edge leaves the flag set in the next cycle
    p_edge_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[j] |=> chan_flag[j]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[j] && !chan_mode[j] && !edge_hit[j] && !(wr_en && wr_ch == IDX_W'(j)))
        |=> !chan_flag[j]);

    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_req[j] && chan_lvl[j*3 +: 3] != 3'd0) |-> win_valid);

    p_no_better_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_valid && chan_req[j] && chan_lvl[j*3 +: 3] > win_lvl));

    p_tie_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_valid && chan_req[j] && chan_lvl[j*3 +: 3] == win_lvl && IDX_W'(j) < win_idx));
  end
endmodule

bind ext_irq_ctrl eirq_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .wr_en(wr_en), .wr_ch(wr_ch),
  .ack(ack), .chan_req(chan_req), .chan_lvl(chan_lvl), .win_valid(win_valid),
  .win_idx(win_idx), .win_lvl(win_lvl), .edge_hit(edge_hit),
  .chan_flag(chan_flag), .chan_mode(chan_mode)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   pin_in;
  logic             wr_en;
  logic [IDX_W-1:0] wr_ch;
  logic [7:0]       wr_data;
  logic [IDX_W-1:0] rd_ch;
  logic [7:0]       rd_data;
  logic [NCH-1:0]   ack;
  logic [NCH-1:0]   chan_req;
  logic [NCH*3-1:0] chan_lvl;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [2:0]       win_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  ext_irq_ctrl #(.NCH(NCH), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data), .ack(ack),
    .chan_req(chan_req), .chan_lvl(chan_lvl), .win_valid(win_valid),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    wr_en = 1'b1; wr_ch = IDX_W'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [7:0] d);
    rd_ch = IDX_W'(ch);
    #1;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      chk("R1 ctl byte", d, 8'h00);
    end
    chk("R1 chan_req", chan_req, 0);
    chk("R1 win_valid", win_valid, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(1, 8'hFF);
    rd(1, d);
    chk("R2 upper bits dropped", d, 8'h3F);
    wr(1, 8'hC5);
    rd(1, d);
    chk("R2 lower bits kept", d, 8'h05);
    chk("R2 level out", chan_lvl[3 +: 3], 3'd5);
    wr(1, 8'h00);
  endtask

  task automatic t_edge_fall;
    logic [7:0] d;
    wr(0, 8'h01);
    pin_in[0] = 1'b1;
    step(4);
    rd(0, d);
    chk("R3 rising ignored", d[3], 0);
    pin_in[0] = 1'b0;
    step(2);
    rd(0, d);
    chk("R3 not yet set", d[3], 0);
    step(1);
    rd(0, d);
    chk("R3 falling sets flag", d[3], 1);
    chk("R3 chan_req", chan_req[0], 1);
    wr(0, 8'h01);
  endtask

  task automatic t_edge_rise;
    logic [7:0] d;
    wr(1, 8'h12);
    pin_in[1] = 1'b1;
    step(3);
    rd(1, d);
    chk("R4 rising sets flag", d[3], 1);
    wr(1, 8'h12);
    pin_in[1] = 1'b0;
    step(4);
    rd(1, d);
    chk("R4 falling ignored", d[3], 0);
  endtask

  task automatic t_level;
    wr(2, 8'h23);
    step(3);
    chk("R5 pin low inactive", chan_req[2], 0);
    wr(2, 8'h2B);
    step(1);
    chk("R5 flag ignored", chan_req[2], 0);
    pin_in[2] = 1'b1;
    step(1);
    chk("R5 not yet", chan_req[2], 0);
    step(1);
    chk("R5 follows high", chan_req[2], 1);
    ack[2] = 1'b1;
    @(negedge clk);
    ack[2] = 1'b0;
    step(1);
    chk("R7 ack no effect in level mode", chan_req[2], 1);
    wr(2, 8'h33);
    chk("R5 polarity 1 high inactive", chan_req[2], 0);
    pin_in[2] = 1'b0;
    step(2);
    chk("R5 polarity 1 low active", chan_req[2], 1);
    wr(2, 8'h00);
    step(1);
    chk("R5 back to edge clear", chan_req[2], 0);
  endtask

  task automatic t_sw_flag;
    logic [7:0] d;
    wr(3, 8'h04);
    pin_in[3] = 1'b1;
    step(4);
    pin_in[3] = 1'b0;
    step(2);
    wr(3, 8'h04);
    rd(3, d);
    chk("R6 edge wins over clear", d, 8'h0C);
    wr(3, 8'h04);
    rd(3, d);
    chk("R6 software clear", d[3], 0);
    wr(3, 8'h0C);
    rd(3, d);
    chk("R6 software set", d[3], 1);
    wr(3, 8'h04);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    wr(0, 8'h09);
    chk("R7 flag before ack", chan_req[0], 1);
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    rd(0, d);
    chk("R7 ack clears flag", d[3], 0);
    chk("R7 ack clears req", chan_req[0], 0);
  endtask

  task automatic t_arb;
    wr(0, 8'h09);
    wr(1, 8'h1A);
    wr(3, 8'h0C);
    chk("R9 highest valid", win_valid, 1);
    chk("R9 highest idx", win_idx, 3);
    chk("R9 highest lvl", win_lvl, 4);
    wr(1, 8'h1C);
    chk("R9 tie lowest idx", win_idx, 1);
    chk("R9 tie lvl", win_lvl, 4);
    wr(1, 8'h18);
    chk("R8 masked still requests", chan_req[1], 1);
    chk("R8 masked skipped", win_idx, 3);
    wr(3, 8'h04);
    chk("R9 next winner idx", win_idx, 0);
    chk("R9 next winner lvl", win_lvl, 1);
    wr(0, 8'h00);
    chk("R8 only masked left", win_valid, 0);
    wr(1, 8'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; wr_ch = '0; wr_data = '0;
    rd_ch = '0; ack = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_edge_fall();
    t_edge_rise();
    t_level();
    t_sw_flag();
    t_ack();
    t_arb();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule